// File: doc/BRIEF.md
# PCM FIFO Interrupt Status Controller

This block sits beside the transmit and receive FIFOs of a serial audio port and turns their conditions into one interrupt line. Fill-level flags (empty, almost-empty, almost-full, full) are derived from the live word counts of each FIFO. Starvation and overflow pulses come from the data path, and a word-transfer pulse marks each serial word moved. Every source sets its own sticky status bit on a rising edge. Software acknowledges a bit by writing a one to the matching position of a clear register.

The status bits are masked with a per-source enable register. The interrupt line is asserted when a global enable is set and at least one enabled status bit is set. The same condition is also shown as a pending bit in the status register. A small register port gives access to the enable, status, clear and live FIFO-level registers. Writes take effect at the next clock edge. Reads are combinational.

Top module: `pcmfifo_irq_ctrl`

## Requirements
- R1: After reset the enable register and the status register read zero and `irq` is low.
- R2: A status bit sets on the first cycle its source is high after being low. It stays set while no clear is written, and a source held high sets it only once.
- R3: Writing to the clear register (address 2) clears exactly the status bits whose write-data bits are one. All other status bits keep their value.
- R4: If a source rises in the same cycle as a clear of its bit, the bit ends up set.
- R5: `irq` and status bit 13 are high exactly when enable bit 14 is one and some status bit in 12:0 is set with its enable bit also set.
- R6: With enable bit 14 at zero, `irq` stays low whatever the status and the per-source enables are.
- R7: The live FIFO register (address 3) reports receive flags and count as follows: full in bit 0, almost-full in bit 1, almost-empty in bit 2, empty in bit 3, count in bits 9:4. It reports transmit flags and count as follows: almost-full in bit 10, full in bit 11, almost-empty in bit 12, empty in bit 13, count in bits 19:14. Almost-empty means count at most MARGIN (4), almost-full means count at least DEPTH minus MARGIN (28), empty means count zero and full means count equal to DEPTH (32).
- R8: Status and enable bits share one layout. Receive sources take bits 5 down to 0: empty, almost-empty, full, almost-full, starvation, overflow. Transmit takes the same order in bits 11 down to 6, and word transfer takes bit 12.
- R9: The enable register (address 0) stores bits 14 and 12:0 of the written data. Bit 13 and bits 31:15 read as zero.
- R10: Writes to the status register (address 1) leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 enable, 1 status, 2 clear, 3 live FIFO |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| rx_count | input | CNT_W | Receive FIFO word count |
| tx_count | input | CNT_W | Transmit FIFO word count |
| rx_starve | input | 1 | Receive starvation event |
| rx_ovfl | input | 1 | Receive overflow event |
| tx_starve | input | 1 | Transmit starvation event |
| tx_ovfl | input | 1 | Transmit overflow event |
| word_xfer | input | 1 | Word transferred event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. A status bit never drops unless a clear named it. The interrupt stays low while the global enable is off. A high interrupt always has an enabled set status bit behind it. The interrupt cannot change while status and enable hold still. Only the bench's scenarios can show the rest: that a held source latches only once, that a clear racing with an event loses, the exact bit positions of each source, and the threshold edges of the live level flags.

// File: rtl/pcmfifo_irq_ctrl.sv
module pcmfifo_irq_ctrl #(
  parameter int DEPTH  = 32,
  parameter int MARGIN = 4,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_starve,
  input  logic             rx_ovfl,
  input  logic             tx_starve,
  input  logic             tx_ovfl,
  input  logic             word_xfer,
  output logic             irq
);
  localparam logic [CNT_W-1:0] LO_TH   = CNT_W'(MARGIN);
  localparam logic [CNT_W-1:0] HI_TH   = CNT_W'(DEPTH - MARGIN);
  localparam logic [CNT_W-1:0] FULL_TH = CNT_W'(DEPTH);
  localparam int NSRC = 13;

  logic [NSRC-1:0] src, src_q, stat_q, clr_vec;
  logic [14:0]     en_q;
  logic rx_e, rx_ae, rx_f, rx_af, tx_e, tx_ae, tx_f, tx_af;

  assign rx_e  = rx_count == '0;
  assign rx_ae = rx_count <= LO_TH;
  assign rx_af = rx_count >= HI_TH;
  assign rx_f  = rx_count == FULL_TH;
  assign tx_e  = tx_count == '0;
  assign tx_ae = tx_count <= LO_TH;
  assign tx_af = tx_count >= HI_TH;
  assign tx_f  = tx_count == FULL_TH;

  assign src = {word_xfer,
                tx_e, tx_ae, tx_f, tx_af, tx_starve, tx_ovfl,
                rx_e, rx_ae, rx_f, rx_af, rx_starve, rx_ovfl};

  assign clr_vec = (reg_wr && reg_addr == 2'd2) ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src;
      stat_q <= (stat_q & ~clr_vec) | (src & ~src_q);
      if (reg_wr && reg_addr == 2'd0)
        en_q <= {reg_wdata[14], 1'b0, reg_wdata[12:0]};
    end
  end

  assign irq = en_q[14] && |(stat_q & en_q[NSRC-1:0]);

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = {17'b0, en_q};
      2'd1:    reg_rdata = {18'b0, irq, stat_q};
      2'd2:    reg_rdata = '0;
      default: reg_rdata = {12'b0, 6'(tx_count), tx_e, tx_ae, tx_f, tx_af,
                            6'(rx_count), rx_e, rx_ae, rx_af, rx_f};
    endcase
  end
endmodule

// File: rtl/pcmfifo_irq_chk.sv
module pcmfifo_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [12:0] stat,
  input logic [14:0] en,
  input logic [12:0] clr
);
  // R2 / R3: a set bit only falls when a clear named it
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~$past(clr) & ~stat) == 13'b0));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en[14] |-> !irq);

  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(stat & en[12:0]));

  p_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(stat) && $stable(en)) |-> $stable(irq));
endmodule

bind pcmfifo_irq_ctrl pcmfifo_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq),
  .stat(stat_q), .en(en_q), .clr(clr_vec)
);

// File: tb/pcmfifo_irq_ctrl_bench.sv
module pcmfifo_irq_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [5:0] rx_count = 0, tx_count = 0;
  logic rx_starve = 0, rx_ovfl = 0, tx_starve = 0, tx_ovfl = 0, word_xfer = 0;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pcmfifo_irq_ctrl u_pcmfifo_irq_ctrl (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); check("R1 enable", d, 0);
    rd(1, d); check("R1 status", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_empty_layout;
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rd(1, d); check("R8 empty sources", d, (1<<5)|(1<<4)|(1<<11)|(1<<10));
  endtask

  task automatic t_levels;
    logic [31:0] d;
    @(negedge clk); rx_count = 28; tx_count = 32;
    rd(3, d); check("R7 high levels", d, (28<<4)|(1<<1)|(32<<14)|(1<<11)|(1<<10));
    @(negedge clk); rx_count = 4; tx_count = 0;
    rd(3, d); check("R7 low levels", d, (4<<4)|(1<<2)|(1<<3)*0|(1<<13)|(1<<12));
    @(negedge clk); rx_count = 5; tx_count = 27;
    rd(3, d); check("R7 mid levels", d, (5<<4)|(27<<14));
    @(negedge clk); rx_count = 0;
    rd(3, d); check("R7 rx empty", d & 32'hF, (1<<3)|(1<<2));
  endtask

  task automatic t_latch;
    logic [31:0] d;
    @(negedge clk); rx_count = 10; tx_count = 10;
    wr(2, 32'h1FFF);
    rd(1, d); check("R3 clear all", d, 0);
    @(negedge clk); rx_ovfl = 1; @(negedge clk); rx_ovfl = 0;
    rd(1, d); check("R2 rx overflow latched", d, 1<<0);
    @(negedge clk); tx_starve = 1; repeat (3) @(negedge clk);
    rd(1, d); check("R8 tx starve bit", d, (1<<0)|(1<<7));
    wr(2, 1<<7);
    repeat (2) @(negedge clk);
    rd(1, d); check("R2 held source latches once", d, 1<<0);
    tx_starve = 0;
    @(negedge clk); word_xfer = 1; @(negedge clk); word_xfer = 0;
    rd(1, d); check("R8 word bit", d, (1<<0)|(1<<12));
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(2, 1<<0);
    rd(1, d); check("R3 partial clear", d, 1<<12);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); rx_ovfl = 1; @(negedge clk); rx_ovfl = 0;
    @(negedge clk); rx_ovfl = 1; reg_addr = 2; reg_wdata = 1; reg_wr = 1;
    @(negedge clk); rx_ovfl = 0; reg_wr = 0;
    rd(1, d); check("R4 event beats clear", d, (1<<0)|(1<<12));
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(0, 1<<0);
    check("R6 no global enable", {31'b0, irq}, 0);
    rd(1, d); check("R6 pending low", d[13], 0);
    wr(0, (1<<14)|(1<<0));
    check("R5 irq high", {31'b0, irq}, 1);
    rd(1, d); check("R5 pending bit", d, (1<<13)|(1<<12)|(1<<0));
    wr(0, (1<<14)|(1<<5));
    check("R5 unmatched enable", {31'b0, irq}, 0);
    wr(0, (1<<14)|(1<<0));
    wr(2, 1<<0);
    check("R5 irq after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R9 enable readback", d, 32'h5FFF);
    wr(1, 32'h0000_0FFF);
    rd(1, d); check("R10 status write ignored", d, (1<<13)|(1<<12));
    wr(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_empty_layout;
    t_levels;
    t_latch;
    t_clear;
    t_collide;
    t_irq;
    t_regs;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule